// File: doc/BRIEF.md
# Staged clock selector and fractional divider with commit triggers

This block holds the configuration of one generated clock: which parent source feeds it, an integer pre-divider, and a downstream divider whose field carries fractional bits. Software-side logic presents new values on staging inputs. Nothing reaches the active settings until a trigger is written. Two triggers exist. The pre-trigger commits the parent selector and the pre-divider together. The main trigger commits the downstream divider. Each trigger reads back as busy while its update is in flight and clears itself once the new values are live, so a controller can poll it.

The downstream divider field holds the divisor minus one. The minus-one applies above the fraction bits, so the scaled divisor (the divisor times two to the fraction width) equals the field value plus one integer step. A phase accumulator advances by one integer step per input cycle and emits a clock-enable pulse each time it reaches the scaled divisor. Over any long window this gives a mean pulse rate of one over the fractional divisor. A selector code that maps to no parent keeps the enable output off. The reset code of the selector is such an unmapped code.

Top module: `clkcfg_divmux`

## Requirements
- R1: After reset both busy outputs are 0, the active selector is code 7 (unmapped, so `sel_valid` is 0), the pre-divisor is 1, the scaled divisor is 16 and no enable pulse is produced.
- R2: The main divider field is 12 bits: bits 11:4 are the integer part and bits 3:0 the fraction. `scaled_div` equals the active field plus 16, so the integer divisor is one more than bits 11:4 and the fraction bits are taken unchanged.
- R3: `pre_divisor` equals the active 4-bit pre-divider field plus one, from 1 up to 16.
- R4: A main trigger accepted at a clock edge makes `busy_main` read 1 for exactly 3 cycles. The staged divider value is applied at the edge where `busy_main` returns to 0. Changing the staging inputs without a trigger never changes `scaled_div`.
- R5: The pre-trigger has the same 3-cycle busy behaviour on `busy_pre` and commits selector and pre-divider only. The main trigger never changes `act_sel` or `pre_divisor`, and the pre-trigger never changes `scaled_div`.
- R6: A trigger of either kind written while `gate_en` is 0 is ignored: its busy output stays 0 and the active values do not change.
- R7: A trigger written while the same trigger is busy is ignored. The value committed is the one staged at the accepted trigger.
- R8: Selector codes 0 to 4 are mapped parents. Codes 5 to 7 are unmapped: `sel_valid` is 0 and `clk_en_pulse` stays 0.
- R9: While running, the accumulator adds 16 per cycle. It pulses in any cycle where accumulator plus 16 reaches `scaled_div`, keeping the excess. It is held at 0 while `busy_main` is 1, so counting starts from 0 after each main commit. Over N cycles from a commit, the pulse count is floor(16·N / scaled_div).
- R10: While `gate_en` is 0, `clk_en_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Clock gate is on; triggers accepted and pulses allowed only when 1 |
| stage_sel | input | 3 | Staged parent selector code |
| stage_prediv | input | 4 | Staged pre-divider field (divisor minus one) |
| stage_div | input | 12 | Staged downstream divider field, 8 integer and 4 fraction bits |
| go_pre | input | 1 | Pre-trigger write strobe |
| go_main | input | 1 | Main trigger write strobe |
| busy_pre | output | 1 | Pre-trigger readback, 1 while its update is in flight |
| busy_main | output | 1 | Main trigger readback, 1 while its update is in flight |
| act_sel | output | 3 | Active parent selector code |
| sel_valid | output | 1 | Active selector code maps to a parent |
| pre_divisor | output | 5 | Active pre-divisor |
| scaled_div | output | 13 | Active downstream divisor scaled by 16 |
| clk_en_pulse | output | 1 | Clock-enable pulse from the phase accumulator |

## Verification
The properties assume that triggers are single-cycle strobes. They also assume the staging inputs are meaningful only at the edge where a trigger is accepted, and that `gate_en` is a level that the controller changes only between updates. The bench drives every strobe for exactly one cycle, between falling edges. It changes `gate_en` only while both busy outputs are 0. It re-strobes a trigger during busy only to show that the strobe is ignored.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [0:0] {
        TRG_IDLE = 1'b0,
        TRG_BUSY = 1'b1
    } trg_state_e;

    // Selector code counts as a parent when it is below the parent count.
    function automatic logic code_mapped(logic [31:0] code, logic [31:0] parents);
        return code < parents;
    endfunction

endpackage

// File: rtl/clkcfg_commit.sv
module clkcfg_commit
    import clkcfg_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned LAT     = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate_en,
    input  logic         go,
    input  logic [W-1:0] stage,
    output logic         busy,
    output logic [W-1:0] active
);
    localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT);

    trg_state_e    state;
    logic [CW-1:0] cnt;
    logic [W-1:0]  hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TRG_IDLE;
            cnt    <= '0;
            hold   <= RST_VAL;
            active <= RST_VAL;
        end else begin
            unique case (state)
                TRG_IDLE: begin
                    if (go && gate_en) begin
                        hold  <= stage;
                        cnt   <= CW'(LAT - 1);
                        state <= TRG_BUSY;
                    end
                end
                TRG_BUSY: begin
                    if (cnt == '0) begin
                        active <= hold;
                        state  <= TRG_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= TRG_IDLE;
            endcase
        end
    end

    assign busy = (state == TRG_BUSY);

endmodule

// File: rtl/clkcfg_phase_acc.sv
module clkcfg_phase_acc #(
    parameter int unsigned SC_W = 13,
    parameter int unsigned STEP = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [SC_W-1:0] scaled,
    output logic            pulse
);
    logic [SC_W-1:0] acc;
    logic [SC_W:0]   sum;

    assign sum   = {1'b0, acc} + (SC_W + 1)'(STEP);
    assign pulse = run && (sum >= {1'b0, scaled});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc <= '0;
        end else if (pulse) begin
            acc <= SC_W'(sum - {1'b0, scaled});
        end else begin
            acc <= sum[SC_W-1:0];
        end
    end

endmodule

// File: rtl/clkcfg_divmux.sv
module clkcfg_divmux
    import clkcfg_pkg::*;
#(
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned NUM_PARENTS = 5,
    parameter int unsigned RESET_SEL   = 7,
    parameter int unsigned PDIV_W      = 4,
    parameter int unsigned INT_W       = 8,
    parameter int unsigned FRAC_W      = 4,
    parameter int unsigned LAT         = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      gate_en,
    input  logic [SEL_W-1:0]          stage_sel,
    input  logic [PDIV_W-1:0]         stage_prediv,
    input  logic [INT_W+FRAC_W-1:0]   stage_div,
    input  logic                      go_pre,
    input  logic                      go_main,
    output logic                      busy_pre,
    output logic                      busy_main,
    output logic [SEL_W-1:0]          act_sel,
    output logic                      sel_valid,
    output logic [PDIV_W:0]           pre_divisor,
    output logic [INT_W+FRAC_W:0]     scaled_div,
    output logic                      clk_en_pulse
);
    localparam int unsigned DIV_W = INT_W + FRAC_W;
    localparam int unsigned SC_W  = DIV_W + 1;
    localparam int unsigned STEP  = 1 << FRAC_W;
    localparam int unsigned PRE_W = SEL_W + PDIV_W;
    localparam logic [PRE_W-1:0] PRE_RST = {SEL_W'(RESET_SEL), PDIV_W'(0)};

    logic [PRE_W-1:0] pre_act;
    logic [DIV_W-1:0] div_act;
    logic             run;

    // Selector and pre-divider share the pre-trigger.
    clkcfg_commit #(.W(PRE_W), .LAT(LAT), .RST_VAL(PRE_RST)) pre_cu (
        .clk     (clk),
        .rst     (rst),
        .gate_en (gate_en),
        .go      (go_pre),
        .stage   ({stage_sel, stage_prediv}),
        .busy    (busy_pre),
        .active  (pre_act)
    );

    // Downstream divider has its own trigger.
    clkcfg_commit #(.W(DIV_W), .LAT(LAT), .RST_VAL('0)) div_cu (
        .clk     (clk),
        .rst     (rst),
        .gate_en (gate_en),
        .go      (go_main),
        .stage   (stage_div),
        .busy    (busy_main),
        .active  (div_act)
    );

    assign act_sel     = pre_act[PRE_W-1 -: SEL_W];
    assign pre_divisor = {1'b0, pre_act[PDIV_W-1:0]} + (PDIV_W + 1)'(1);
    // The stored minus-one lives above the fraction bits.
    assign scaled_div  = {1'b0, div_act} + SC_W'(STEP);
    assign sel_valid   = code_mapped(32'(act_sel), 32'(NUM_PARENTS));
    assign run         = gate_en && sel_valid && !busy_main;

    clkcfg_phase_acc #(.SC_W(SC_W), .STEP(STEP)) acc_u (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .scaled (scaled_div),
        .pulse  (clk_en_pulse)
    );

endmodule

// File: rtl/clkcfg_divmux_chk.sv
module clkcfg_divmux_chk #(
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned NUM_PARENTS = 5,
    parameter int unsigned SC_W        = 13,
    parameter int unsigned STEP        = 16,
    parameter int unsigned LAT         = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             gate_en,
    input logic             busy_pre,
    input logic             busy_main,
    input logic [SEL_W-1:0] act_sel,
    input logic [SC_W-1:0]  scaled_div,
    input logic             clk_en_pulse
);
    logic [7:0] bcnt_main;
    logic [7:0] bcnt_pre;
    logic       mapped;

    assign mapped = (32'(act_sel) < NUM_PARENTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_main <= '0;
            bcnt_pre  <= '0;
        end else begin
            bcnt_main <= busy_main ? bcnt_main + 8'd1 : 8'd0;
            bcnt_pre  <= busy_pre  ? bcnt_pre  + 8'd1 : 8'd0;
        end
    end

    p_main_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_main) |-> (32'(bcnt_main) == LAT));

    p_main_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !busy_main |=> $stable(scaled_div));

    p_pre_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_pre) |-> (32'(bcnt_pre) == LAT));

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !busy_pre |=> $stable(act_sel));

    p_gate_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && !busy_main && !busy_pre) |=> (!busy_main && !busy_pre));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> !clk_en_pulse);

    p_unit_div_r9: assert property (@(posedge clk) disable iff (rst)
        (gate_en && mapped && !busy_main && scaled_div == SC_W'(STEP)) |-> clk_en_pulse);

    p_gate_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !gate_en |-> !clk_en_pulse);

    p_floor_r2: assert property (@(posedge clk) disable iff (rst)
        scaled_div >= SC_W'(STEP));

endmodule

bind clkcfg_divmux clkcfg_divmux_chk #(
    .SEL_W       (SEL_W),
    .NUM_PARENTS (NUM_PARENTS),
    .SC_W        (SC_W),
    .STEP        (STEP),
    .LAT         (LAT)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .gate_en      (gate_en),
    .busy_pre     (busy_pre),
    .busy_main    (busy_main),
    .act_sel      (act_sel),
    .scaled_div   (scaled_div),
    .clk_en_pulse (clk_en_pulse)
);

// File: tb/clkcfg_divmux_tb_top.sv
`timescale 1ns/1ps
module clkcfg_divmux_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate_en = 1'b1;
    logic [2:0]  stage_sel = '0;
    logic [3:0]  stage_prediv = '0;
    logic [11:0] stage_div = '0;
    logic        go_pre = 1'b0;
    logic        go_main = 1'b0;
    logic        busy_pre, busy_main, sel_valid, clk_en_pulse;
    logic [2:0]  act_sel;
    logic [4:0]  pre_divisor;
    logic [12:0] scaled_div;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    clkcfg_divmux dut_i (
        .clk(clk), .rst(rst), .gate_en(gate_en),
        .stage_sel(stage_sel), .stage_prediv(stage_prediv), .stage_div(stage_div),
        .go_pre(go_pre), .go_main(go_main),
        .busy_pre(busy_pre), .busy_main(busy_main),
        .act_sel(act_sel), .sel_valid(sel_valid),
        .pre_divisor(pre_divisor), .scaled_div(scaled_div),
        .clk_en_pulse(clk_en_pulse)
    );

    // Vectors: divider field, window length, expected pulse count (R2, R9).
    localparam int NV = 5;
    localparam logic [11:0] V_DIV [NV] = '{12'h000, 12'h010, 12'h008, 12'h025, 12'h0F0};
    localparam int          V_WIN [NV] = '{12, 12, 12, 53, 64};
    localparam int          V_EXP [NV] = '{12, 6, 8, 16, 4};

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_main(logic [11:0] f);
        stage_div = f;
        go_main = 1'b1;
        tick();
        go_main = 1'b0;
    endtask

    task automatic strobe_pre(logic [2:0] s, logic [3:0] p);
        stage_sel = s;
        stage_prediv = p;
        go_pre = 1'b1;
        tick();
        go_pre = 1'b0;
    endtask

    task automatic count_pulses(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (clk_en_pulse) cnt++;
            tick();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        int prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy_main", busy_main, 0);
        chk("R1 busy_pre", busy_pre, 0);
        chk("R1 act_sel", act_sel, 7);
        chk("R1 sel_valid", sel_valid, 0);
        chk("R1 pre_divisor", pre_divisor, 1);
        chk("R1 scaled_div", scaled_div, 16);
        chk("R1 pulse", clk_en_pulse, 0);

        // R4: staging alone changes nothing
        stage_div = 12'h0AB;
        stage_sel = 3'd1;
        repeat (3) tick();
        chk("R4 staged no effect", scaled_div, 16);
        chk("R5 staged sel no effect", act_sel, 7);

        // R5: pre-trigger timing and scope
        strobe_pre(3'd2, 4'd3);
        chk("R5 busy_pre first", busy_pre, 1);
        tick(); tick();
        chk("R5 busy_pre third", busy_pre, 1);
        chk("R5 sel old during busy", act_sel, 7);
        tick();
        chk("R5 busy_pre clear", busy_pre, 0);
        chk("R5 act_sel", act_sel, 2);
        chk("R3 pre_divisor", pre_divisor, 4);
        chk("R8 mapped", sel_valid, 1);
        chk("R5 scaled untouched", scaled_div, 16);

        // R2 R4 R9: table walk
        prev = 16;
        for (int v = 0; v < NV; v++) begin
            strobe_main(V_DIV[v]);
            chk("R4 busy_main set", busy_main, 1);
            tick(); tick();
            chk("R4 busy_main held", busy_main, 1);
            chk("R4 old value held", scaled_div, prev);
            tick();
            chk("R4 busy_main clear", busy_main, 0);
            chk("R2 scaled_div", scaled_div, int'(V_DIV[v]) + 16);
            prev = int'(V_DIV[v]) + 16;
            count_pulses(V_WIN[v], cnt);
            chk("R9 pulse count", cnt, V_EXP[v]);
            chk("R5 main keeps sel", act_sel, 2);
        end

        // R10, R6: gate off
        gate_en = 1'b0;
        count_pulses(8, cnt);
        chk("R10 no pulses gate off", cnt, 0);
        strobe_main(12'h050);
        chk("R6 main ignored", busy_main, 0);
        strobe_pre(3'd3, 4'd9);
        chk("R6 pre ignored", busy_pre, 0);
        repeat (3) tick();
        chk("R6 scaled unchanged", scaled_div, prev);
        chk("R6 sel unchanged", act_sel, 2);
        gate_en = 1'b1;
        tick();

        // R7: retrigger during busy ignored
        strobe_main(12'h010);
        stage_div = 12'h030;
        go_main = 1'b1;
        tick();
        go_main = 1'b0;
        tick();
        chk("R7 still busy", busy_main, 1);
        tick();
        chk("R7 busy clear", busy_main, 0);
        chk("R7 first value kept", scaled_div, 32);

        // R8: unmapped codes
        strobe_pre(3'd6, 4'd0);
        repeat (3) tick();
        chk("R8 code6 unmapped", sel_valid, 0);
        count_pulses(10, cnt);
        chk("R8 no pulses", cnt, 0);
        strobe_pre(3'd5, 4'd15);
        repeat (3) tick();
        chk("R8 code5 unmapped", sel_valid, 0);
        chk("R3 pre_divisor max", pre_divisor, 16);
        strobe_pre(3'd4, 4'd0);
        repeat (3) tick();
        chk("R8 code4 mapped", sel_valid, 1);
        chk("R3 pre_divisor min", pre_divisor, 1);
        count_pulses(4, cnt);
        chk("R9 resumes", cnt, 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule